// File: doc/BRIEF.md
# Interrupt Enable and Pending Register Bank

This block keeps, for each peripheral interrupt source, one enable bit, one pending bit and one 8-bit priority value. Software reaches that state through a small synchronous register bus. Enable and pending state each sit behind a pair of word addresses: one word sets bits where ones are written, and the other word clears them. A trigger register pends a source chosen by its number. Priority values are packed four to a 32-bit word and can be written byte by byte.

Hardware side: a rising edge on a source's level input line marks that source pending. The downstream arbiter sees a per-source request flag that is high when the source is both pending and enabled. The arbiter also receives every priority value. When the arbiter acknowledges a source by its index, that source's pending bit clears.

Source numbers 0 to 15 are reserved for system exceptions and hold no state here. Peripheral source n (n ≥ 16) has local index i = n − 16. That index selects bit i mod 32 of state word i / 32.

Top module: `irq_bank`

## Requirements
- R1: After reset, every enable, pending and priority value is zero, so req_o, prio_o and every register read are zero.
- R2: Writing to set-enable word w (address 0x00 + w) enables each source 32·w + b whose bit b is 1, and zero bits change nothing. Reading address 0x00 + w or 0x08 + w returns enable word w.
- R3: Writing to clear-enable word w (address 0x08 + w) disables each source whose bit is 1, and leaves the others unchanged.
- R4: Set-pending word w (0x10 + w) and clear-pending word w (0x18 + w) set or clear pending bits in the same way. Reading either address returns pending word w.
- R5: Writing value v to the trigger register (address 0x20) marks local source v pending.
- R6: A low-to-high transition of irq_i[i] sets pending bit i. A line that stays high does not set the bit again after the bit has been cleared.
- R7: A cycle with ack_i high clears the pending bit of local source ack_src_i.
- R8: req_o[i] is high exactly when source i is both pending and enabled. The pending bit is kept while the source is disabled.
- R9: Priority word k sits at address 0x40 + k. Byte b (bits 8b+7..8b) of word k holds the priority of source number 4k + b. Only the bytes whose bus_be bit is 1 are written, and prio_o[8i+7:8i] carries the priority of local source i.
- R10: The following are ignored on write and read as zero: state bits at or above NUM_SRC, state words beyond the last one implemented, priority bytes for source numbers below 16 or at or above 16 + NUM_SRC, and trigger values of NUM_SRC or more.
- R11: When one cycle both sets and clears the same pending bit, the bit ends up set.
- R12: A write takes effect at the clock edge where bus_we is high. bus_rdata follows bus_addr combinationally from the current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables, used by priority words |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_i | input | NUM_SRC | Level interrupt lines |
| ack_i | input | 1 | Arbiter acknowledge |
| ack_src_i | input | IDX_W | Local index being acknowledged |
| req_o | output | NUM_SRC | Pending-and-enabled flag per source |
| prio_o | output | 8*NUM_SRC | Priority byte per source |

## Verification
The hardest cases to reach are collisions in which a set and a clear land on the same pending bit in the same cycle. The bench produces them in two ways. In the first, a clear-pending write arrives on the very edge where a line rises. In the second, an acknowledge and a trigger name the same source together. A related subtle case is a line held high across a software clear. To reach it, the bench keeps the line up across the clear and confirms that the bit stays clear until the line falls and rises again.

// File: rtl/irqb_pkg.sv
package irqb_pkg;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 32;
    localparam int PRIO_W    = 8;
    localparam int SYS_SLOTS = 16;
    localparam int WORD_SEL_W = 6;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_EN_SET,
        RG_EN_CLR,
        RG_PD_SET,
        RG_PD_CLR,
        RG_TRIG,
        RG_PRIO
    } region_e;

    typedef struct packed {
        region_e                 region;
        logic [WORD_SEL_W-1:0]   word;
    } dec_t;
endpackage

// File: rtl/irqb_decode.sv
module irqb_decode
    import irqb_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    output dec_t              dec_o
);
    always_comb begin
        dec_o.region = RG_NONE;
        dec_o.word   = '0;
        if (addr_i[7:6] == 2'b01) begin
            dec_o.region = RG_PRIO;
            dec_o.word   = addr_i[5:0];
        end else if (addr_i[7:5] == 3'b000) begin
            dec_o.word = {3'b000, addr_i[2:0]};
            unique case (addr_i[4:3])
                2'd0: dec_o.region = RG_EN_SET;
                2'd1: dec_o.region = RG_EN_CLR;
                2'd2: dec_o.region = RG_PD_SET;
                default: dec_o.region = RG_PD_CLR;
            endcase
        end else if (addr_i[4:0] == 5'd0 && addr_i[7:5] == 3'b001) begin
            dec_o.region = RG_TRIG;
        end
    end
endmodule

// File: rtl/irqb_bitbank.sv
module irqb_bitbank #(
    parameter int NUM_SRC = 40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] state_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] bits;
    } bank_t;

    bank_t bank_d, bank_q;

    // set has precedence over clear in the same cycle
    always_comb begin
        bank_d      = bank_q;
        bank_d.bits = (bank_q.bits & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign state_o = bank_q.bits;
endmodule

// File: rtl/irqb_prio.sv
module irqb_prio
    import irqb_pkg::*;
#(
    parameter int NUM_SRC = 40
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_i,
    input  logic [WORD_SEL_W-1:0]     wword_i,
    input  logic [3:0]                be_i,
    input  logic [DATA_W-1:0]         wdata_i,
    input  logic [WORD_SEL_W-1:0]     rword_i,
    output logic [DATA_W-1:0]         rdata_o,
    output logic [PRIO_W*NUM_SRC-1:0] prio_o
);
    logic [PRIO_W-1:0] pri_d [NUM_SRC];
    logic [PRIO_W-1:0] pri_q [NUM_SRC];

    always_comb begin
        for (int k = 0; k < NUM_SRC; k++) begin
            pri_d[k] = pri_q[k];
            if (wr_i && ((k + SYS_SLOTS) / 4 == int'(wword_i))
                     && be_i[(k + SYS_SLOTS) % 4]) begin
                pri_d[k] = wdata_i[PRIO_W*((k + SYS_SLOTS) % 4) +: PRIO_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_SRC; k++) pri_q[k] <= '0;
        end else begin
            for (int k = 0; k < NUM_SRC; k++) pri_q[k] <= pri_d[k];
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            if ((k + SYS_SLOTS) / 4 == int'(rword_i))
                rdata_o[PRIO_W*((k + SYS_SLOTS) % 4) +: PRIO_W] = pri_q[k];
        end
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_out
        assign prio_o[PRIO_W*g +: PRIO_W] = pri_q[g];
    end
endmodule

// File: rtl/irq_bank.sv
module irq_bank
    import irqb_pkg::*;
#(
    parameter int NUM_SRC = 40,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    input  logic [3:0]                bus_be,
    input  logic                      bus_we,
    output logic [DATA_W-1:0]         bus_rdata,
    input  logic [NUM_SRC-1:0]        irq_i,
    input  logic                      ack_i,
    input  logic [IDX_W-1:0]          ack_src_i,
    output logic [NUM_SRC-1:0]        req_o,
    output logic [PRIO_W*NUM_SRC-1:0] prio_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] irq_prev;
    } edge_t;

    edge_t              edge_d, edge_q;
    dec_t               dec;
    logic [NUM_SRC-1:0] wmask;
    logic [NUM_SRC-1:0] trig_hot, ack_hot, rise;
    logic [NUM_SRC-1:0] en_set, en_clr, pd_set, pd_clr;
    logic [NUM_SRC-1:0] en_state, pend_state;
    logic [NUM_SRC-1:0] irq_prev;
    logic [DATA_W-1:0]  prio_rd, en_word, pend_word;

    irqb_decode u_dec (.addr_i(bus_addr), .dec_o(dec));

    // expand the written word onto the source bits it covers
    always_comb begin
        wmask = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (k / DATA_W == int'(dec.word)) wmask[k] = bus_wdata[k % DATA_W];
        end
    end

    always_comb begin
        trig_hot = '0;
        ack_hot  = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (bus_we && dec.region == RG_TRIG && bus_wdata == DATA_W'(k)) trig_hot[k] = 1'b1;
            if (ack_i && ack_src_i == IDX_W'(k)) ack_hot[k] = 1'b1;
        end
    end

    always_comb begin
        edge_d          = edge_q;
        edge_d.irq_prev = irq_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) edge_q <= '0;
        else        edge_q <= edge_d;
    end

    assign irq_prev = edge_q.irq_prev;
    assign rise     = irq_i & ~edge_q.irq_prev;

    assign en_set = (bus_we && dec.region == RG_EN_SET) ? wmask : '0;
    assign en_clr = (bus_we && dec.region == RG_EN_CLR) ? wmask : '0;
    assign pd_set = ((bus_we && dec.region == RG_PD_SET) ? wmask : '0) | trig_hot | rise;
    assign pd_clr = ((bus_we && dec.region == RG_PD_CLR) ? wmask : '0) | ack_hot;

    irqb_bitbank #(.NUM_SRC(NUM_SRC)) u_en (
        .clk(clk), .rst_n(rst_n), .set_i(en_set), .clr_i(en_clr), .state_o(en_state)
    );

    irqb_bitbank #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk(clk), .rst_n(rst_n), .set_i(pd_set), .clr_i(pd_clr), .state_o(pend_state)
    );

    irqb_prio #(.NUM_SRC(NUM_SRC)) u_prio (
        .clk(clk), .rst_n(rst_n),
        .wr_i(bus_we && dec.region == RG_PRIO), .wword_i(dec.word),
        .be_i(bus_be), .wdata_i(bus_wdata),
        .rword_i(dec.word), .rdata_o(prio_rd), .prio_o(prio_o)
    );

    always_comb begin
        en_word   = '0;
        pend_word = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (k / DATA_W == int'(dec.word)) begin
                en_word[k % DATA_W]   = en_state[k];
                pend_word[k % DATA_W] = pend_state[k];
            end
        end
    end

    always_comb begin
        unique case (dec.region)
            RG_EN_SET, RG_EN_CLR: bus_rdata = en_word;
            RG_PD_SET, RG_PD_CLR: bus_rdata = pend_word;
            RG_PRIO:              bus_rdata = prio_rd;
            default:              bus_rdata = '0;
        endcase
    end

    assign req_o = pend_state & en_state;
endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk #(
    parameter int NUM_SRC = 40,
    parameter int IDX_W   = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_we,
    input logic [7:0]           bus_addr,
    input logic                 wdata0,
    input logic [3:0]           bus_be,
    input logic                 ack_i,
    input logic [IDX_W-1:0]     ack_src_i,
    input logic                 irq0,
    input logic                 irq_prev0,
    input logic                 en0,
    input logic [NUM_SRC-1:0]   pend_q,
    input logic [8*NUM_SRC-1:0] prio_o
);
    a_r2_set_enable: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && bus_addr == 8'h00 && wdata0 |=> en0);

    a_r3_clear_enable: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && bus_addr == 8'h08 && wdata0 |=> !en0);

    a_r6_rise_pends: assert property (@(posedge clk) disable iff (!rst_n)
        irq0 && !irq_prev0 |=> pend_q[0]);

    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i && ack_src_i == '0 && !bus_we && !(irq0 && !irq_prev0) |=> !pend_q[0]);

    a_r8_pend_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we && !ack_i |=> (($past(pend_q) & ~pend_q) == '0));

    a_r9_no_byte_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && bus_be == 4'h0 |=> $stable(prio_o));
endmodule

bind irq_bank irq_bank_chk #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .wdata0(bus_wdata[0]), .bus_be(bus_be), .ack_i(ack_i), .ack_src_i(ack_src_i),
    .irq0(irq_i[0]), .irq_prev0(irq_prev[0]), .en0(en_state[0]),
    .pend_q(pend_state), .prio_o(prio_o)
);

// File: tb/irq_bank_bench.sv
module irq_bank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC       = 40;
    localparam int IW         = 6;
    localparam int NVEC       = 14;

    typedef struct packed {
        logic [31:0] tag;
        logic [7:0]  wa;
        logic [31:0] wd;
        logic [3:0]  be;
        logic [7:0]  ra;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{"R2",  8'h00, 32'h0000_0005, 4'hF, 8'h00, 32'h0000_0005},
        '{"R2",  8'h00, 32'h0000_0010, 4'hF, 8'h08, 32'h0000_0015},
        '{"R3",  8'h08, 32'h0000_0004, 4'hF, 8'h00, 32'h0000_0011},
        '{"R10", 8'h01, 32'hFFFF_FFFF, 4'hF, 8'h01, 32'h0000_00FF},
        '{"R10", 8'h02, 32'hFFFF_FFFF, 4'hF, 8'h02, 32'h0000_0000},
        '{"R4",  8'h10, 32'h0000_0003, 4'hF, 8'h18, 32'h0000_0003},
        '{"R4",  8'h18, 32'h0000_0001, 4'hF, 8'h10, 32'h0000_0002},
        '{"R5",  8'h20, 32'd36,        4'hF, 8'h11, 32'h0000_0010},
        '{"R10", 8'h20, 32'd40,        4'hF, 8'h11, 32'h0000_0010},
        '{"R9",  8'h44, 32'hAABB_CCDD, 4'hF, 8'h44, 32'hAABB_CCDD},
        '{"R9",  8'h44, 32'h1122_3344, 4'h2, 8'h44, 32'hAABB_33DD},
        '{"R10", 8'h43, 32'hFFFF_FFFF, 4'hF, 8'h43, 32'h0000_0000},
        '{"R9",  8'h4D, 32'h0102_0304, 4'hF, 8'h4D, 32'h0102_0304},
        '{"R10", 8'h4E, 32'hFFFF_FFFF, 4'hF, 8'h4E, 32'h0000_0000}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [7:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [3:0]      bus_be = '0;
    logic            bus_we = 1'b0;
    logic [31:0]     bus_rdata;
    logic [NSRC-1:0] irq_i = '0;
    logic            ack_i = 1'b0;
    logic [IW-1:0]   ack_src_i = '0;
    logic [NSRC-1:0] req_o;
    logic [8*NSRC-1:0] prio_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_bank #(.NUM_SRC(NSRC)) u_irq_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_be(bus_be), .bus_we(bus_we), .bus_rdata(bus_rdata), .irq_i(irq_i),
        .ack_i(ack_i), .ack_src_i(ack_src_i), .req_o(req_o), .prio_o(prio_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(tag, 64'(bus_rdata), 64'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 req", 64'(req_o), 64'h0);
        chk("R1 prio", 64'(|prio_o), 64'h0);
        rd("R1 rd", 8'h00, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            wr(VECS[i].wa, VECS[i].wd, VECS[i].be);
            rd($sformatf("%s vec%0d", VECS[i].tag, i), VECS[i].ra, VECS[i].exp);
        end

        // R8: only source 36 is both pending and enabled
        chk("R8 req", 64'(req_o), 64'h10_0000_0000);
        wr(8'h09, 32'h10, 4'hF);
        chk("R8 disabled", 64'(req_o), 64'h0);
        rd("R8 kept", 8'h11, 32'h10);
        wr(8'h01, 32'h10, 4'hF);
        chk("R8 reenabled", 64'(req_o), 64'h10_0000_0000);

        // R7 acknowledge
        @(negedge clk);
        ack_i = 1'b1; ack_src_i = IW'(36);
        @(negedge clk);
        ack_i = 1'b0;
        rd("R7 ack", 8'h11, 32'h0);
        chk("R7 req", 64'(req_o), 64'h0);

        // R6 edge detection and held level
        irq_i[5] = 1'b1;
        @(negedge clk);
        rd("R6 rise", 8'h10, 32'h22);
        wr(8'h18, 32'h20, 4'hF);
        @(negedge clk);
        rd("R6 held", 8'h10, 32'h02);
        irq_i[5] = 1'b0;
        @(negedge clk);
        irq_i[5] = 1'b1;
        @(negedge clk);
        rd("R6 rerise", 8'h10, 32'h22);

        // R11 clear write against rising edge
        bus_addr = 8'h18; bus_wdata = 32'h80; bus_be = 4'hF; bus_we = 1'b1;
        irq_i[7] = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        rd("R11 edge", 8'h10, 32'hA2);

        // R11 acknowledge against trigger
        bus_addr = 8'h20; bus_wdata = 32'd1; bus_we = 1'b1;
        ack_i = 1'b1; ack_src_i = IW'(1);
        @(negedge clk);
        bus_we = 1'b0; ack_i = 1'b0;
        rd("R11 trig", 8'h10, 32'hA2);

        // R9 priority outputs
        chk("R9 p36", 64'(prio_o[8*36 +: 8]), 64'h04);
        chk("R9 p39", 64'(prio_o[8*39 +: 8]), 64'h01);
        chk("R9 p1",  64'(prio_o[8*1 +: 8]),  64'h33);
        chk("R9 p2",  64'(prio_o[8*2 +: 8]),  64'hBB);

        // R12 read follows address with no write
        rd("R12 rd en", 8'h00, 32'h11);

        // R1 reset mid-run
        rst_n = 1'b0;
        #1;
        chk("R1 req2", 64'(req_o), 64'h0);
        chk("R1 prio2", 64'(|prio_o), 64'h0);
        rd("R1 pend", 8'h10, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule